// File: doc/BRIEF.md
# Timestamp NCO with register interface

This block keeps a free-running nanosecond time of day for a chip that stamps packets or events. On each cycle of its 125 MHz clock, a numerically controlled oscillator adds a programmable 32-bit rate word to a wide accumulator. The accumulator has a 28-bit fractional nanosecond part below a 44-bit integer nanosecond count. The integer count is driven on a port for the timestamping logic. Software reaches it through four word registers.

The count is held as three fields. The low nibble is bits [3:0], the middle word is bits [35:4] and the top byte is bits [43:36]. Each field has its own register. The top byte is read back in bits [7:0] but is written on data bits [15:8]. Software sets a new time by writing the low field with zero, then the middle word, then the top byte. The default rate word 0x8000_0000 gives exactly 8 ns per cycle. A rate word of zero freezes time, and any other value makes the count advance at a proportional rate.

Top module: `ts_nco`

## Requirements
- R1: While `rst` is high at a clock edge, the time goes to zero, the fraction is cleared and the rate word returns to 0x8000_0000. After that edge `time_ns` reads 0.
- R2: With the default rate word and no write, `time_ns` advances by exactly 8 on every clock.
- R3: On each clock with no write, the rate word, taken in units of 2^-28 ns, is added to the 72-bit value {time, fraction}. Rate words within ±5% of the default (0x7999_999A to 0x8666_6666) make the count advance at that proportional rate, with the fraction carried exactly from one cycle to the next.
- R4: A rate word of zero holds `time_ns` constant. Writing a non-zero rate word later resumes counting from the held value.
- R5: A write to word 0 (byte offset 0x00, `addr[3:2]`=0) replaces time bits [3:0] with write data bits [3:0]. It leaves the other time bits unchanged and clears the fraction.
- R6: A write to word 1 (offset 0x04) replaces time bits [35:4] with the 32-bit write data. It leaves the other time bits unchanged and clears the fraction.
- R7: A write to word 2 (offset 0x08) replaces time bits [43:36] with write data bits [15:8]. It leaves the other time bits unchanged and clears the fraction.
- R8: A write to word 3 (offset 0x0C) loads the rate word. `time_ns` does not advance in any cycle that carries a write, to any word.
- R9: A read is sampled on the clock edge where `rd_en` is high and appears on `rd_data` after that edge. The values returned are: word 0, time [3:0] with zeros above; word 1, time [35:4]; word 2, time [43:36] in bits [7:0] with zeros above; word 3, the rate word. A read returns the state from before that edge's update.
- R10: The count wraps modulo 2^44. For example, 0xFFF_FFFF_FFFF plus 8 ns gives 7.
- R11: `rd_data` holds its last value on any clock where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz time base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address; bits [3:2] select the word |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data |
| time_ns | output | 44 | Live integer nanosecond count |

## Verification
The hardest case to reach is the wrap at 2^44 ns. Counting there from reset would take hours, so the bench writes all three fields to their maximum and then lets the default rate carry past the top. A second hard-to-reach case is a fractional carry that only shows up after many cycles at an off-nominal rate. To reach it, random phases load rate words drawn from the ±5% band and run long idle stretches. Every cycle is compared against a 72-bit model in the bench. Zero-rate freezes and write-priority cycles are mixed into the random stream so that they also land at arbitrary fractional phases.

// File: rtl/ts_nco_pkg.sv
package ts_nco_pkg;

   // word index taken from addr[3:2]; order fixes the software-visible offsets
   typedef enum logic [1:0] {
      SEL_LOW  = 2'd0,
      SEL_MID  = 2'd1,
      SEL_HIGH = 2'd2,
      SEL_RATE = 2'd3
   } reg_sel_e;

   localparam int unsigned DEF_LOW_W  = 4;
   localparam int unsigned DEF_MID_W  = 32;
   localparam int unsigned DEF_HIGH_W = 8;
   localparam int unsigned DEF_FRAC_W = 28;
   localparam int unsigned DEF_BUS_W  = 32;

endpackage

// File: rtl/ts_nco_accum.sv
module ts_nco_accum #(
   parameter int unsigned LOW_W  = 4,
   parameter int unsigned MID_W  = 32,
   parameter int unsigned HIGH_W = 8,
   parameter int unsigned FRAC_W = 28,
   parameter int unsigned RATE_W = 32,
   localparam int unsigned NS_W  = LOW_W + MID_W + HIGH_W,
   localparam int unsigned ACC_W = NS_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  logic              ld_low,
   input  logic              ld_mid,
   input  logic              ld_high,
   input  logic [LOW_W-1:0]  low_d,
   input  logic [MID_W-1:0]  mid_d,
   input  logic [HIGH_W-1:0] high_d,
   input  logic [RATE_W-1:0] rate,
   output logic [NS_W-1:0]   ns_o
);

   localparam int unsigned MID_LSB  = FRAC_W + LOW_W;
   localparam int unsigned HIGH_LSB = MID_LSB + MID_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;

   generate
      if (RATE_W >= ACC_W) begin : g_bad_rate
         $error("rate word must be narrower than the accumulator");
      end
   endgenerate

   assign acc_sum = acc_q + {{(ACC_W-RATE_W){1'b0}}, rate};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (ld_low | ld_mid | ld_high) begin
         acc_q[FRAC_W-1:0] <= '0;
         if (ld_low)  acc_q[FRAC_W +: LOW_W]   <= low_d;
         if (ld_mid)  acc_q[MID_LSB +: MID_W]  <= mid_d;
         if (ld_high) acc_q[HIGH_LSB +: HIGH_W] <= high_d;
      end else if (!hold) begin
         acc_q <= acc_sum;
      end
   end

   assign ns_o = acc_q[ACC_W-1:FRAC_W];

endmodule

// File: rtl/ts_nco_regs.sv
module ts_nco_regs
   import ts_nco_pkg::*;
#(
   parameter int unsigned LOW_W     = 4,
   parameter int unsigned MID_W     = 32,
   parameter int unsigned HIGH_W    = 8,
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned HIGH_LANE = 8,
   parameter logic [BUS_W-1:0] RATE_RESET = 32'h8000_0000,
   parameter bit          READ_REG  = 1'b1,
   localparam int unsigned NS_W = LOW_W + MID_W + HIGH_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic [NS_W-1:0]   ns_i,
   output logic              ld_low,
   output logic              ld_mid,
   output logic              ld_high,
   output logic [LOW_W-1:0]  low_d,
   output logic [MID_W-1:0]  mid_d,
   output logic [HIGH_W-1:0] high_d,
   output logic [BUS_W-1:0]  rate_o,
   output logic [BUS_W-1:0]  rd_data
);

   localparam int unsigned MID_LSB  = LOW_W;
   localparam int unsigned HIGH_LSB = LOW_W + MID_W;

   reg_sel_e         sel;
   logic [BUS_W-1:0] rate_q;
   logic [BUS_W-1:0] rd_mux;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("address must reach byte offset 0x0C");
      end
      if (MID_W != BUS_W) begin : g_bad_mid
         $error("middle field must fill one bus word");
      end
      if (HIGH_LANE + HIGH_W > BUS_W) begin : g_bad_lane
         $error("high write lane exceeds bus width");
      end
   endgenerate

   assign sel = reg_sel_e'(addr[3:2]);

   assign ld_low  = wr_en && (sel == SEL_LOW);
   assign ld_mid  = wr_en && (sel == SEL_MID);
   assign ld_high = wr_en && (sel == SEL_HIGH);
   assign low_d   = wr_data[LOW_W-1:0];
   assign mid_d   = wr_data[MID_W-1:0];
   assign high_d  = wr_data[HIGH_LANE +: HIGH_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         rate_q <= RATE_RESET;
      end else if (wr_en && (sel == SEL_RATE)) begin
         rate_q <= wr_data;
      end
   end

   assign rate_o = rate_q;

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_LOW:  rd_mux[LOW_W-1:0]  = ns_i[LOW_W-1:0];
         SEL_MID:  rd_mux             = ns_i[MID_LSB +: MID_W];
         SEL_HIGH: rd_mux[HIGH_W-1:0] = ns_i[HIGH_LSB +: HIGH_W];
         SEL_RATE: rd_mux             = rate_q;
         default:  rd_mux             = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_flop
         logic [BUS_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               rd_q <= '0;
            end else if (rd_en) begin
               rd_q <= rd_mux;
            end
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = rd_en ? rd_mux : '0;
      end
   endgenerate

endmodule

// File: rtl/ts_nco.sv
module ts_nco
   import ts_nco_pkg::*;
#(
   parameter int unsigned LOW_W     = DEF_LOW_W,
   parameter int unsigned MID_W     = DEF_MID_W,
   parameter int unsigned HIGH_W    = DEF_HIGH_W,
   parameter int unsigned FRAC_W    = DEF_FRAC_W,
   parameter int unsigned BUS_W     = DEF_BUS_W,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned HIGH_LANE = 8,
   parameter logic [BUS_W-1:0] RATE_RESET = 32'h8000_0000,
   parameter bit          READ_REG  = 1'b1,
   localparam int unsigned NS_W = LOW_W + MID_W + HIGH_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [BUS_W-1:0]  rd_data,
   output logic [NS_W-1:0]   time_ns
);

   logic              ld_low, ld_mid, ld_high;
   logic [LOW_W-1:0]  low_d;
   logic [MID_W-1:0]  mid_d;
   logic [HIGH_W-1:0] high_d;
   logic [BUS_W-1:0]  rate_q;

   ts_nco_regs #(
      .LOW_W(LOW_W), .MID_W(MID_W), .HIGH_W(HIGH_W), .BUS_W(BUS_W),
      .ADDR_W(ADDR_W), .HIGH_LANE(HIGH_LANE), .RATE_RESET(RATE_RESET),
      .READ_REG(READ_REG)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .ns_i(time_ns),
      .ld_low(ld_low), .ld_mid(ld_mid), .ld_high(ld_high),
      .low_d(low_d), .mid_d(mid_d), .high_d(high_d),
      .rate_o(rate_q), .rd_data(rd_data)
   );

   ts_nco_accum #(
      .LOW_W(LOW_W), .MID_W(MID_W), .HIGH_W(HIGH_W),
      .FRAC_W(FRAC_W), .RATE_W(BUS_W)
   ) u_accum (
      .clk(clk), .rst(rst), .hold(wr_en),
      .ld_low(ld_low), .ld_mid(ld_mid), .ld_high(ld_high),
      .low_d(low_d), .mid_d(mid_d), .high_d(high_d),
      .rate(rate_q), .ns_o(time_ns)
   );

endmodule

// File: rtl/ts_nco_chk.sv
module ts_nco_chk #(
   parameter int unsigned NS_W      = 44,
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned HIGH_W    = 8,
   parameter int unsigned HIGH_LANE = 8,
   parameter logic [BUS_W-1:0] RATE_RESET = 32'h8000_0000,
   parameter bit          READ_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [BUS_W-1:0]  wr_data,
   input logic [BUS_W-1:0]  rd_data,
   input logic [NS_W-1:0]   time_ns,
   input logic [BUS_W-1:0]  rate_q
);

   localparam int unsigned HIGH_LSB = NS_W - HIGH_W;
   localparam logic [NS_W-1:0] STEP = NS_W'(8);

   // R1: reset clears the time
   a_r1_reset_clear: assert property (@(posedge clk) rst |=> (time_ns == '0));

   // R2 / R10: default rate, no write -> +8 ns modulo 2^44
   a_r2_default_step: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && rate_q == RATE_RESET) |=> (time_ns == $past(time_ns) + STEP));

   // R4: zero rate freezes time
   a_r4_zero_freeze: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && rate_q == '0) |=> $stable(time_ns));

   // R8: a rate write cycle does not advance time
   a_r8_write_holds: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr[3:2] == 2'd3) |=> $stable(time_ns));

   // R7: high byte loaded from the shifted lane, rest untouched
   a_r7_high_lane: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr[3:2] == 2'd2) |=>
      (time_ns[NS_W-1:HIGH_LSB] == $past(wr_data[HIGH_LANE +: HIGH_W]) &&
       time_ns[HIGH_LSB-1:0] == $past(time_ns[HIGH_LSB-1:0])));

   generate
      if (READ_REG) begin : g_rd_hold
         // R11: read data is held without a read strobe
         a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
            !rd_en |=> $stable(rd_data));
      end
   endgenerate

endmodule

bind ts_nco ts_nco_chk #(
   .NS_W(NS_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .HIGH_W(HIGH_W),
   .HIGH_LANE(HIGH_LANE), .RATE_RESET(RATE_RESET), .READ_REG(READ_REG)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wr_data(wr_data), .rd_data(rd_data), .time_ns(time_ns), .rate_q(rate_q)
);

// File: tb/ts_nco_test.sv
module ts_nco_test;

   localparam int CLK_P = 8;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en, rd_en;
   logic [3:0]  addr;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic [43:0] time_ns;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // independent model
   logic [71:0] m_acc;
   logic [31:0] m_rate;
   logic [31:0] m_rd;

   always #(CLK_P/2) clk = ~clk;

   ts_nco uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .time_ns(time_ns)
   );

   function automatic logic [31:0] exp_read(input logic [1:0] w);
      logic [43:0] t;
      t = m_acc[71:28];
      case (w)
         2'd0:    exp_read = {28'd0, t[3:0]};
         2'd1:    exp_read = t[35:4];
         2'd2:    exp_read = {24'd0, t[43:36]};
         default: exp_read = m_rate;
      endcase
   endfunction

   function automatic logic [71:0] exp_next(input logic we, input logic [1:0] w,
                                            input logic [31:0] d);
      logic [71:0] a;
      a = m_acc;
      if (!we) a = a + {40'd0, m_rate};
      else if (w != 2'd3) begin
         a[27:0] = '0;
         case (w)
            2'd0:    a[31:28] = d[3:0];
            2'd1:    a[63:32] = d;
            default: a[71:64] = d[15:8];
         endcase
      end
      exp_next = a;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, update model, sample at next negedge
   task automatic step(input logic we, input logic re, input logic [1:0] w,
                       input logic [31:0] d, input string req);
      wr_en = we; rd_en = re; addr = {w, 2'b00}; wr_data = d;
      if (re) m_rd = exp_read(w);
      m_acc = exp_next(we, w, d);
      if (we && w == 2'd3) m_rate = d;
      @(posedge clk);
      @(negedge clk);
      check({req, " time"}, {20'd0, time_ns}, {20'd0, m_acc[71:28]});
      check({req, " rd"}, {32'd0, rd_data}, {32'd0, m_rd});
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 32'd0, req);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd20240611);
      rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
      m_acc = '0; m_rate = 32'h8000_0000; m_rd = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check("R1 time", {20'd0, time_ns}, 64'd0);
      step(1'b0, 1'b1, 2'd3, 32'd0, "R1 rate");
      check("R1 rate value", {32'd0, rd_data}, 64'h8000_0000);
      // R2: 8 ns per cycle
      idle(5, "R2");
      check("R2 count", {20'd0, time_ns}, 64'd48);
      // R5/R6/R7: load a time the software way
      step(1'b1, 1'b0, 2'd0, 32'h0, "R5");
      step(1'b1, 1'b0, 2'd1, 32'h1234_5678, "R6");
      step(1'b1, 1'b0, 2'd2, 32'h0000_AB00, "R7");
      check("R7 loaded", {20'd0, time_ns}, 64'hAB_1234_5678_0);
      // R9: read every word
      for (int w = 0; w < 4; w++) step(1'b0, 1'b1, 2'(w), 32'd0, "R9");
      // R11: rd_data held without strobe
      idle(3, "R11");
      // R10: wrap at 2^44
      step(1'b1, 1'b0, 2'd0, 32'hF, "R5 low");
      step(1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF, "R6 mid");
      step(1'b1, 1'b0, 2'd2, 32'h0000_FF00, "R7 high");
      step(1'b0, 1'b0, 2'd0, 32'd0, "R10");
      check("R10 wrap", {20'd0, time_ns}, 64'd7);
      // R4: zero rate freezes, nonzero resumes
      step(1'b1, 1'b0, 2'd3, 32'd0, "R4 stop");
      idle(6, "R4");
      check("R4 frozen", {20'd0, time_ns}, 64'd7);
      step(1'b1, 1'b0, 2'd3, 32'h8000_0000, "R4 go");
      idle(2, "R4 resume");
      check("R4 resumed", {20'd0, time_ns}, 64'd23);
      // R3: band edges with fractional carry
      step(1'b1, 1'b0, 2'd3, 32'h8666_6666, "R3 fast");
      idle(100, "R3 fast");
      step(1'b1, 1'b0, 2'd3, 32'h7999_999A, "R3 slow");
      idle(100, "R3 slow");
      // random mix
      for (int k = 0; k < 3000; k++) begin
         int unsigned r;
         logic [1:0]  w;
         logic [31:0] d;
         r = $urandom % 100;
         w = 2'($urandom);
         d = $urandom;
         if (w == 2'd3) begin
            if ($urandom % 8 == 0) d = 32'd0;
            else d = 32'h7999_999A + ($urandom % 32'h0CCC_CCCD);
         end
         if (r < 70)      step(1'b0, ($urandom % 3) == 0, w, d, "R3 rand");
         else if (r < 85) step(1'b1, 1'b0, w, d, "R8 rand");
         else             step(1'b1, 1'b1, w, d, "R9 rand");
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule